// File: doc/BRIEF.md
# Received Frame Drain Sequencer

This block empties the circular receive buffer of an external SPI Ethernet controller one frame at a time. When the controller's packet-pending interrupt is high, the sequencer reads the pending-frame count. If frames are waiting, it loads the controller's buffer read pointer with the next-frame address it saved earlier. It then fetches the 6-byte header and the payload in a single buffer-read transaction. Payload bytes leave on a valid/ready byte stream. The header's CRC-OK flag is carried along as an error sideband on every byte of the frame.

After the payload has been delivered, the block releases the frame. It writes the header's next-frame address into the controller's free pointer. It then sets the frame-decrement bit in the second control register. It keeps the new address as the start of the next frame, so each frame's header chains to the one after it. It loops until the count reads zero.

All controller accesses go out through a request port to a separate command engine. Each request carries a 3-bit operation code whose value the engine decodes into the SPI opcode. Each read request returns one byte on the response port. SPI shifting, register banking and higher protocol layers belong elsewhere.

Top module: `rxFrameSequencer`

## Requirements
- R1: While reset is held, and in the cycle after it, neither a command request (cmdValid) nor a stream byte (outValid) is offered.
- R2: With the interrupt high, the first request is a register read (op 3'b000) of the count register (address CNT_ADDR, default 5'h19). A count of zero leads to no request other than count reads and to no stream byte.
- R3: Before the first buffer read of a frame, the read pointer is written low byte then high byte (op 3'b010, RD_LO_ADDR 5'h00, RD_HI_ADDR 5'h01). For the first frame after reset, the value is the parameter RX_START (default 16'h0100).
- R4: Header and payload are fetched with buffer-read requests (op 3'b001) in one transaction. cmdLast is 0 on every such request but the last and 1 on the last, so the transaction holds exactly 6 + byte-count requests. A request is held stable until accepted, and a new request is not issued while a read response is outstanding.
- R5: The header is little-endian: next pointer in bytes 0-1, byte count in bytes 2-3, status in bytes 4-5. Exactly byte-count payload bytes are streamed in buffer order. outLast is 1 only on the final one.
- R6: outBad is 1 on every byte of a frame whose status bit CRC_OK_BIT (default 7, i.e. header byte 4 bit 7) is 0, and 0 on every byte of a frame where it is 1.
- R7: After the fetch transaction ends, the free pointer is written low then high (FREE_LO_ADDR 5'h0C, FREE_HI_ADDR 5'h0D) with the header's next pointer. Then a bit-set request (op 3'b100) goes to CTRL2_ADDR 5'h1E with data DEC_MASK 8'h40.
- R8: Each following frame's read pointer is the next pointer from the previous frame's header. Frames are drained in order until the count reads zero.
- R9: While outValid is 1 and outReady is 0, outValid, outData, outLast and outBad hold their values. No request is issued while a byte is offered.
- R10: A frame with byte count zero streams no byte. Its sixth header request carries cmdLast = 1, and it is still released as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 1 | Packet-pending interrupt, level, active high |
| cmdValid | output | 1 | Command request offered |
| cmdReady | input | 1 | Command engine accepts the request |
| cmdOp | output | 3 | Operation: 000 reg read, 001 buffer read, 010 reg write, 100 bit set |
| cmdAddr | output | 5 | Register address or fixed buffer-read argument |
| cmdData | output | 8 | Write data or bit mask |
| cmdLast | output | 1 | Request ends the SPI transaction |
| rspValid | input | 1 | Read response byte present |
| rspData | input | 8 | Read response byte |
| outValid | output | 1 | Payload byte offered |
| outReady | input | 1 | Consumer takes the byte |
| outData | output | 8 | Payload byte |
| outLast | output | 1 | Final byte of the frame |
| outBad | output | 1 | Frame failed its CRC check |

## Verification
A directed batch first raises the interrupt with a zero count, which separates "read and stop" from a sequencer that runs on regardless. A second directed batch then chains an empty frame, a one-byte frame, a frame with a cleared CRC flag and noise in the other status bits, and a normal frame. This exposes header field mix-ups, off-by-one lengths, a misplaced transaction end and a wrong status bit. Two random batches follow, with random lengths, CRC flags and status noise. The command engine and the consumer stall at random, which tests that requests and stream bytes hold under backpressure and that pointers chain in order across many frames.

// File: rtl/rxSeqPkg.sv
package rxSeqPkg;

  localparam int HDR_BYTES = 6;
  localparam int PTR_W = 16;

  typedef enum logic [2:0] {
    OP_RD_REG   = 3'b000,
    OP_RD_BUF   = 3'b001,
    OP_WR_REG   = 3'b010,
    OP_SET_BITS = 3'b100
  } cmdOpE;

  typedef enum logic [2:0] {
    SEL_CNT,
    SEL_RD_LO,
    SEL_RD_HI,
    SEL_BUF,
    SEL_FREE_LO,
    SEL_FREE_HI,
    SEL_DEC
  } cmdSelE;

  typedef struct packed {
    cmdSelE sel;
    logic   payPhase;
    logic   hdrClear;
    logic   hdrCapture;
    logic   loadRemain;
    logic   payCapture;
    logic   payTaken;
    logic   commitNext;
  } ctrlStrobeT;

endpackage

// File: rtl/rxSeqCtrl.sv
module rxSeqCtrl
  import rxSeqPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       irq,
  input  logic       cmdReady,
  input  logic       rspValid,
  input  logic       outReady,
  input  logic       cntZero,
  input  logic       hdrLastByte,
  input  logic       byteCntZero,
  input  logic       payFinal,
  output logic       cmdValid,
  output logic       outValid,
  output ctrlStrobeT strobe
);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CNT_REQ,
    ST_CNT_WAIT,
    ST_RD_LO,
    ST_RD_HI,
    ST_HDR_REQ,
    ST_HDR_WAIT,
    ST_PAY_REQ,
    ST_PAY_WAIT,
    ST_PAY_OUT,
    ST_FREE_LO,
    ST_FREE_HI,
    ST_DEC
  } stateE;

  stateE state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe = '0;
    strobe.sel = SEL_CNT;
    cmdValid = 1'b0;
    outValid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (irq) stateNext = ST_CNT_REQ;
      end
      ST_CNT_REQ: begin
        cmdValid = 1'b1;
        strobe.sel = SEL_CNT;
        if (cmdReady) stateNext = ST_CNT_WAIT;
      end
      ST_CNT_WAIT: begin
        if (rspValid) begin
          if (cntZero) stateNext = ST_IDLE;
          else begin
            stateNext = ST_RD_LO;
            strobe.hdrClear = 1'b1;
          end
        end
      end
      ST_RD_LO: begin
        cmdValid = 1'b1;
        strobe.sel = SEL_RD_LO;
        if (cmdReady) stateNext = ST_RD_HI;
      end
      ST_RD_HI: begin
        cmdValid = 1'b1;
        strobe.sel = SEL_RD_HI;
        if (cmdReady) stateNext = ST_HDR_REQ;
      end
      ST_HDR_REQ: begin
        cmdValid = 1'b1;
        strobe.sel = SEL_BUF;
        if (cmdReady) stateNext = ST_HDR_WAIT;
      end
      ST_HDR_WAIT: begin
        strobe.sel = SEL_BUF;
        if (rspValid) begin
          strobe.hdrCapture = 1'b1;
          if (hdrLastByte) begin
            strobe.loadRemain = 1'b1;
            stateNext = byteCntZero ? ST_FREE_LO : ST_PAY_REQ;
          end else begin
            stateNext = ST_HDR_REQ;
          end
        end
      end
      ST_PAY_REQ: begin
        cmdValid = 1'b1;
        strobe.sel = SEL_BUF;
        strobe.payPhase = 1'b1;
        if (cmdReady) stateNext = ST_PAY_WAIT;
      end
      ST_PAY_WAIT: begin
        strobe.sel = SEL_BUF;
        strobe.payPhase = 1'b1;
        if (rspValid) begin
          strobe.payCapture = 1'b1;
          stateNext = ST_PAY_OUT;
        end
      end
      ST_PAY_OUT: begin
        outValid = 1'b1;
        strobe.sel = SEL_BUF;
        strobe.payPhase = 1'b1;
        if (outReady) begin
          strobe.payTaken = 1'b1;
          stateNext = payFinal ? ST_FREE_LO : ST_PAY_REQ;
        end
      end
      ST_FREE_LO: begin
        cmdValid = 1'b1;
        strobe.sel = SEL_FREE_LO;
        if (cmdReady) stateNext = ST_FREE_HI;
      end
      ST_FREE_HI: begin
        cmdValid = 1'b1;
        strobe.sel = SEL_FREE_HI;
        if (cmdReady) stateNext = ST_DEC;
      end
      ST_DEC: begin
        cmdValid = 1'b1;
        strobe.sel = SEL_DEC;
        if (cmdReady) begin
          strobe.commitNext = 1'b1;
          stateNext = ST_CNT_REQ;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/rxSeqDatapath.sv
module rxSeqDatapath
  import rxSeqPkg::*;
#(
  parameter logic [PTR_W-1:0] RX_START     = 16'h0100,
  parameter logic [4:0]       CNT_ADDR     = 5'h19,
  parameter logic [4:0]       RD_LO_ADDR   = 5'h00,
  parameter logic [4:0]       RD_HI_ADDR   = 5'h01,
  parameter logic [4:0]       FREE_LO_ADDR = 5'h0C,
  parameter logic [4:0]       FREE_HI_ADDR = 5'h0D,
  parameter logic [4:0]       CTRL2_ADDR   = 5'h1E,
  parameter logic [4:0]       BUF_ARG      = 5'h1A,
  parameter logic [7:0]       DEC_MASK     = 8'h40,
  parameter int               CRC_OK_BIT   = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  ctrlStrobeT strobe,
  input  logic [7:0] rspData,
  output logic       cntZero,
  output logic       hdrLastByte,
  output logic       byteCntZero,
  output logic       payFinal,
  output logic [2:0] cmdOp,
  output logic [4:0] cmdAddr,
  output logic [7:0] cmdData,
  output logic       cmdLast,
  output logic [7:0] outData,
  output logic       outLast,
  output logic       outBad
);

  localparam int IDX_W = $clog2(HDR_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_BYTES - 1);

  logic [IDX_W-1:0] hdrIdx;
  logic [7:0]       hdrBytes [HDR_BYTES];
  logic [PTR_W-1:0] nextPtr;
  logic [PTR_W-1:0] newPtr;
  logic [15:0]      byteCount;
  logic [15:0]      statusWord;
  logic [15:0]      remain;

  always_ff @(posedge clk) begin
    if (rst || strobe.hdrClear) hdrIdx <= '0;
    else if (strobe.hdrCapture) hdrIdx <= hdrIdx + 1'b1;
  end

  for (genvar g = 0; g < HDR_BYTES; g++) begin : gHdr
    always_ff @(posedge clk) begin
      if (rst) hdrBytes[g] <= '0;
      else if (strobe.hdrCapture && hdrIdx == IDX_W'(g)) hdrBytes[g] <= rspData;
    end
  end

  assign newPtr     = {hdrBytes[1], hdrBytes[0]};
  assign byteCount  = {hdrBytes[3], hdrBytes[2]};
  assign statusWord = {hdrBytes[5], hdrBytes[4]};

  always_ff @(posedge clk) begin
    if (rst) nextPtr <= RX_START;
    else if (strobe.commitNext) nextPtr <= newPtr;
  end

  always_ff @(posedge clk) begin
    if (rst) remain <= '0;
    else if (strobe.loadRemain) remain <= byteCount;
    else if (strobe.payTaken) remain <= remain - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outData <= '0;
      outLast <= 1'b0;
    end else if (strobe.payCapture) begin
      outData <= rspData;
      outLast <= payFinal;
    end
  end

  assign outBad      = ~statusWord[CRC_OK_BIT];
  assign cntZero     = (rspData == 8'd0);
  assign hdrLastByte = (hdrIdx == IDX_LAST);
  assign byteCntZero = (byteCount == 16'd0);
  assign payFinal    = (remain == 16'd1);

  always_comb begin
    cmdOp   = OP_RD_REG;
    cmdAddr = CNT_ADDR;
    cmdData = '0;
    cmdLast = 1'b1;
    unique case (strobe.sel)
      SEL_CNT: begin
        cmdOp   = OP_RD_REG;
        cmdAddr = CNT_ADDR;
      end
      SEL_RD_LO: begin
        cmdOp   = OP_WR_REG;
        cmdAddr = RD_LO_ADDR;
        cmdData = nextPtr[7:0];
      end
      SEL_RD_HI: begin
        cmdOp   = OP_WR_REG;
        cmdAddr = RD_HI_ADDR;
        cmdData = nextPtr[15:8];
      end
      SEL_BUF: begin
        cmdOp   = OP_RD_BUF;
        cmdAddr = BUF_ARG;
        cmdLast = strobe.payPhase ? payFinal : (hdrLastByte && byteCntZero);
      end
      SEL_FREE_LO: begin
        cmdOp   = OP_WR_REG;
        cmdAddr = FREE_LO_ADDR;
        cmdData = newPtr[7:0];
      end
      SEL_FREE_HI: begin
        cmdOp   = OP_WR_REG;
        cmdAddr = FREE_HI_ADDR;
        cmdData = newPtr[15:8];
      end
      SEL_DEC: begin
        cmdOp   = OP_SET_BITS;
        cmdAddr = CTRL2_ADDR;
        cmdData = DEC_MASK;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rxFrameSequencer.sv
module rxFrameSequencer
  import rxSeqPkg::*;
#(
  parameter logic [15:0] RX_START     = 16'h0100,
  parameter logic [4:0]  CNT_ADDR     = 5'h19,
  parameter logic [4:0]  RD_LO_ADDR   = 5'h00,
  parameter logic [4:0]  RD_HI_ADDR   = 5'h01,
  parameter logic [4:0]  FREE_LO_ADDR = 5'h0C,
  parameter logic [4:0]  FREE_HI_ADDR = 5'h0D,
  parameter logic [4:0]  CTRL2_ADDR   = 5'h1E,
  parameter logic [4:0]  BUF_ARG      = 5'h1A,
  parameter logic [7:0]  DEC_MASK     = 8'h40,
  parameter int          CRC_OK_BIT   = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       irq,
  output logic       cmdValid,
  input  logic       cmdReady,
  output logic [2:0] cmdOp,
  output logic [4:0] cmdAddr,
  output logic [7:0] cmdData,
  output logic       cmdLast,
  input  logic       rspValid,
  input  logic [7:0] rspData,
  output logic       outValid,
  input  logic       outReady,
  output logic [7:0] outData,
  output logic       outLast,
  output logic       outBad
);

  ctrlStrobeT strobe;
  logic cntZero, hdrLastByte, byteCntZero, payFinal;

  rxSeqCtrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .irq        (irq),
    .cmdReady   (cmdReady),
    .rspValid   (rspValid),
    .outReady   (outReady),
    .cntZero    (cntZero),
    .hdrLastByte(hdrLastByte),
    .byteCntZero(byteCntZero),
    .payFinal   (payFinal),
    .cmdValid   (cmdValid),
    .outValid   (outValid),
    .strobe     (strobe)
  );

  rxSeqDatapath #(
    .RX_START    (RX_START),
    .CNT_ADDR    (CNT_ADDR),
    .RD_LO_ADDR  (RD_LO_ADDR),
    .RD_HI_ADDR  (RD_HI_ADDR),
    .FREE_LO_ADDR(FREE_LO_ADDR),
    .FREE_HI_ADDR(FREE_HI_ADDR),
    .CTRL2_ADDR  (CTRL2_ADDR),
    .BUF_ARG     (BUF_ARG),
    .DEC_MASK    (DEC_MASK),
    .CRC_OK_BIT  (CRC_OK_BIT)
  ) i_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .rspData    (rspData),
    .cntZero    (cntZero),
    .hdrLastByte(hdrLastByte),
    .byteCntZero(byteCntZero),
    .payFinal   (payFinal),
    .cmdOp      (cmdOp),
    .cmdAddr    (cmdAddr),
    .cmdData    (cmdData),
    .cmdLast    (cmdLast),
    .outData    (outData),
    .outLast    (outLast),
    .outBad     (outBad)
  );

endmodule

// File: rtl/rxFrameSeqChecker.sv
module rxFrameSeqChecker (
  input logic       clk,
  input logic       rst,
  input logic       cmdValid,
  input logic       cmdReady,
  input logic [2:0] cmdOp,
  input logic [4:0] cmdAddr,
  input logic [7:0] cmdData,
  input logic       cmdLast,
  input logic       rspValid,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outData,
  input logic       outLast,
  input logic       outBad
);

  logic readPending;

  always_ff @(posedge clk) begin
    if (rst) readPending <= 1'b0;
    else if (rspValid) readPending <= 1'b0;
    else if (cmdValid && cmdReady && (cmdOp == 3'b000 || cmdOp == 3'b001)) readPending <= 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !cmdValid && !outValid); // R1

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdOp) && $stable(cmdAddr)
      && $stable(cmdData) && $stable(cmdLast)); // R4

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    readPending |-> !cmdValid); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast)
      && $stable(outBad)); // R9

  AST_NO_CMD_WHILE_OUT: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !cmdValid); // R9

endmodule

bind rxFrameSequencer rxFrameSeqChecker i_rxFrameSeqChecker (
  .clk     (clk),
  .rst     (rst),
  .cmdValid(cmdValid),
  .cmdReady(cmdReady),
  .cmdOp   (cmdOp),
  .cmdAddr (cmdAddr),
  .cmdData (cmdData),
  .cmdLast (cmdLast),
  .rspValid(rspValid),
  .outValid(outValid),
  .outReady(outReady),
  .outData (outData),
  .outLast (outLast),
  .outBad  (outBad)
);

// File: tb/test_rxFrameSequencer.sv
module test_rxFrameSequencer;

  localparam logic [15:0] RX_START = 16'h0100;
  localparam logic [4:0]  CNT_ADDR = 5'h19;
  localparam logic [4:0]  RD_LO    = 5'h00;
  localparam logic [4:0]  RD_HI    = 5'h01;
  localparam logic [4:0]  FREE_LO  = 5'h0C;
  localparam logic [4:0]  FREE_HI  = 5'h0D;
  localparam logic [4:0]  CTRL2    = 5'h1E;
  localparam logic [7:0]  DEC_MASK = 8'h40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq = 1'b0;
  logic cmdValid, cmdReady = 1'b0;
  logic [2:0] cmdOp;
  logic [4:0] cmdAddr;
  logic [7:0] cmdData;
  logic cmdLast;
  logic rspValid = 1'b0;
  logic [7:0] rspData = 8'h00;
  logic outValid, outReady = 1'b0;
  logic [7:0] outData;
  logic outLast, outBad;

  always #5 clk = ~clk;

  rxFrameSequencer #(
    .RX_START(RX_START), .CNT_ADDR(CNT_ADDR), .RD_LO_ADDR(RD_LO), .RD_HI_ADDR(RD_HI),
    .FREE_LO_ADDR(FREE_LO), .FREE_HI_ADDR(FREE_HI), .CTRL2_ADDR(CTRL2),
    .BUF_ARG(5'h1A), .DEC_MASK(DEC_MASK), .CRC_OK_BIT(7)
  ) i_rxFrameSequencer (
    .clk(clk), .rst(rst), .irq(irq),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .cmdLast(cmdLast), .rspValid(rspValid), .rspData(rspData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outLast(outLast), .outBad(outBad)
  );

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // controller model state
  logic [7:0] mem [0:2047];
  int pktCount = 0;
  logic [15:0] rdPtr = 16'h0;
  logic [15:0] freePtr = 16'h0;
  bit inTxn = 0;
  int rbmCnt = 0;
  int fetchFrame = 0;
  int relFrame = 0;
  int otherCmds = 0;
  int cntReads = 0;
  bit forceIrq = 0;
  bit firstSeen = 0;

  int frStart [0:63];
  int frNext  [0:63];
  int frLen   [0:63];
  int frameTotal = 0;
  int placePtr = int'(RX_START);

  logic [7:0] expByte [0:2047];
  bit expLast [0:2047];
  bit expBad  [0:2047];
  int expTotal = 0;
  int gotIdx = 0;

  function automatic logic [7:0] statusLow(input bit ok, input logic [6:0] noise);
    return {ok, noise};
  endfunction

  task automatic addFrame(input int len, input bit ok);
    int start;
    int nxt;
    start = placePtr;
    nxt = start + 6 + len;
    frStart[frameTotal] = start;
    frNext[frameTotal] = nxt;
    frLen[frameTotal] = len;
    mem[start & 2047]       = nxt[7:0];
    mem[(start + 1) & 2047] = nxt[15:8];
    mem[(start + 2) & 2047] = len[7:0];
    mem[(start + 3) & 2047] = len[15:8];
    mem[(start + 4) & 2047] = statusLow(ok, 7'($urandom));
    mem[(start + 5) & 2047] = 8'($urandom);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      mem[(start + 6 + i) & 2047] = b;
      expByte[expTotal] = b;
      expLast[expTotal] = (i == len - 1);
      expBad[expTotal] = !ok;
      expTotal++;
    end
    frameTotal++;
    placePtr = nxt;
  endtask

  task automatic handleCmd(input logic [2:0] op, input logic [4:0] addr,
                           input logic [7:0] data, input logic last);
    if (!firstSeen) begin
      firstSeen = 1;
      chk(op == 3'b000 && addr == CNT_ADDR, "R2 first request is count read", {op, addr}, {3'b000, CNT_ADDR});
    end
    case (op)
      3'b000: begin
        cntReads++;
        chk(addr == CNT_ADDR, "R2 register read address", addr, CNT_ADDR);
        rspValid = 1'b1;
        rspData = 8'(pktCount);
      end
      3'b010: begin
        otherCmds++;
        if (addr == RD_LO) rdPtr[7:0] = data;
        else if (addr == RD_HI) rdPtr[15:8] = data;
        else if (addr == FREE_LO) begin
          chk(!inTxn, "R7 free write after transaction", inTxn, 0);
          freePtr[7:0] = data;
        end else if (addr == FREE_HI) begin
          freePtr[15:8] = data;
          chk(freePtr == 16'(frNext[relFrame]), "R7 free pointer value", freePtr, frNext[relFrame]);
        end else chk(0, "R7 register write address", addr, 0);
      end
      3'b001: begin
        otherCmds++;
        if (!inTxn) begin
          if (fetchFrame == 0)
            chk(rdPtr == RX_START, "R3 first read pointer", rdPtr, RX_START);
          else
            chk(rdPtr == 16'(frStart[fetchFrame]), "R8 chained read pointer", rdPtr, frStart[fetchFrame]);
          inTxn = 1;
          rbmCnt = 0;
        end
        rspValid = 1'b1;
        rspData = mem[rdPtr & 16'h07FF];
        rdPtr = rdPtr + 16'd1;
        rbmCnt++;
        if (last) begin
          if (frLen[fetchFrame] == 0)
            chk(rbmCnt == 6, "R10 empty frame transaction length", rbmCnt, 6);
          else
            chk(rbmCnt == 6 + frLen[fetchFrame], "R4 transaction length", rbmCnt, 6 + frLen[fetchFrame]);
          inTxn = 0;
          fetchFrame++;
        end else if (rbmCnt > 6 + frLen[fetchFrame]) begin
          chk(0, "R4 missing transaction end", rbmCnt, 6 + frLen[fetchFrame]);
        end
      end
      3'b100: begin
        otherCmds++;
        chk(addr == CTRL2 && data == DEC_MASK, "R7 decrement request", {addr, data}, {CTRL2, DEC_MASK});
        chk(freePtr == 16'(frNext[relFrame]), "R7 free before decrement", freePtr, frNext[relFrame]);
        if (pktCount > 0) pktCount--;
        relFrame++;
      end
      default: chk(0, "R2 unknown op", op, 0);
    endcase
  endtask

  task automatic handleOut(input logic [7:0] d, input logic l, input logic b);
    if (gotIdx >= expTotal) begin
      chk(0, "R5 unexpected stream byte", gotIdx, expTotal);
    end else begin
      chk(d == expByte[gotIdx], "R5 payload byte", d, expByte[gotIdx]);
      chk(l == expLast[gotIdx], "R5 last marker", l, expLast[gotIdx]);
      chk(b == expBad[gotIdx], "R6 bad flag", b, expBad[gotIdx]);
    end
    gotIdx++;
  endtask

  bit lastCmdX = 0, lastOutX = 0, holdPending = 0;
  logic [2:0] lOp; logic [4:0] lAddr; logic [7:0] lData; logic lLast;
  logic [7:0] lOutD, holdD; logic lOutL, lOutB;
  int holdChecks = 0;

  initial begin
    forever begin
      @(negedge clk);
      rspValid = 1'b0;
      if (!rst) begin
        if (lastCmdX) handleCmd(lOp, lAddr, lData, lLast);
        if (lastOutX) handleOut(lOutD, lOutL, lOutB);
        if (holdPending && holdChecks < 20) begin
          holdChecks++;
          chk(outValid && outData == holdD, "R9 stream holds under stall", outData, holdD);
        end
      end
      cmdReady = ($urandom % 4) != 0;
      outReady = ($urandom % 3) != 0;
      irq = (pktCount != 0) || forceIrq;
      lastCmdX = !rst && cmdValid && cmdReady;
      lOp = cmdOp; lAddr = cmdAddr; lData = cmdData; lLast = cmdLast;
      lastOutX = !rst && outValid && outReady;
      lOutD = outData; lOutL = outLast; lOutB = outBad;
      holdPending = !rst && outValid && !outReady;
      holdD = outData;
    end
  end

  task automatic waitDrained();
    while (!(relFrame == frameTotal && gotIdx == expTotal && pktCount == 0)) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    chk(!cmdValid && !outValid, "R1 quiet in reset", {cmdValid, outValid}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!cmdValid && !outValid, "R1 quiet after reset", {cmdValid, outValid}, 0);

    // zero count with interrupt high
    forceIrq = 1;
    repeat (60) @(negedge clk);
    forceIrq = 0;
    repeat (20) @(negedge clk);
    chk(cntReads > 0, "R2 count read issued", cntReads, 1);
    chk(otherCmds == 0, "R2 nothing beyond count read", otherCmds, 0);
    chk(gotIdx == 0 && !outValid, "R2 no stream on zero count", gotIdx, 0);

    // directed chain: empty, one byte, bad CRC, normal
    addFrame(0, 1);
    addFrame(1, 1);
    addFrame(3, 0);
    addFrame(5, 1);
    pktCount = 4;
    waitDrained();

    for (int batch = 0; batch < 2; batch++) begin
      int n;
      n = 10;
      for (int f = 0; f < n; f++) addFrame(int'($urandom % 40), ($urandom % 4) != 0);
      pktCount = n;
      waitDrained();
    end

    chk(fetchFrame == frameTotal, "R8 all frames fetched in order", fetchFrame, frameTotal);
    chk(relFrame == frameTotal, "R7 all frames released", relFrame, frameTotal);
    chk(gotIdx == expTotal, "R5 all payload bytes seen", gotIdx, expTotal);
    chk(!cmdValid && !outValid, "R8 idle after count reaches zero", {cmdValid, outValid}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule